// File: doc/BRIEF.md
# Iterative ARX permutation core

This block applies a keyless 256-bit permutation to a state of eight 32-bit words. The words form four branches, each a pair (x, y). A start pulse captures the state and a requested number of steps. The core then performs one full step on every clock cycle until that number is reached. It then raises a one-cycle done pulse, and the permuted state is available on the output.

A step has three parts, in a fixed order. First, two words of branch 0 and branch 1 are modified: one takes a table constant chosen by the step index, the other takes the step index itself. Next, each branch passes through a nonlinear add-rotate-xor box, keyed by a fixed per-branch constant. Last, a Feistel-like linear layer mixes the left pair of branches into the right pair and rotates the branch order. The caller chooses the step count to select a lighter or a stronger variant.

Top module: `arx_perm_core`

## Requirements
- R1: While the synchronous active-high reset `rst` is asserted at a clock edge, busy and done go to 0 and state_out goes to all zeros.
- R2: A start accepted while busy is low with steps = n ≥ 1 loads state_in and raises busy from the next cycle. Busy stays high for exactly n cycles. Done is high in the cycle right after the last busy cycle, so done appears n clock edges after the edge that captured start.
- R3: A start accepted with steps = 0 leaves busy low and raises done in the next cycle. In that cycle state_out equals the captured state_in unchanged.
- R4: Step s (s = 0 .. n−1) first XORs y0 with constant K[s mod 8] and XORs y1 with s zero-extended to 32 bits. The constants are K[0..7] = 0xB7E15162, 0xBF715880, 0x38B4DA56, 0x324E7738, 0xBB1185EB, 0x4F7C7B57, 0xCFBFA1C8, 0xC2B3293D.
- R5: Next, every branch i (0..3) passes through a box keyed by c = K[i], whatever the step number. With ror meaning rotate right, the box runs four rounds on (x, y), using the rotation pairs (31,24), (17,17), (0,31) and (24,16). For a pair (a,b), one round is x += ror(y,a); y ^= ror(x,b); x ^= c.
- R6: Finally, the linear layer computes tx = L(x0^x1) and ty = L(y0^y1), where L(v) = ror(v ^ (v<<16), 16). The new branches are x0' = x3^ty^x1, x1' = x2^ty^x0, x2' = x0, x3' = x1. Likewise y0' = y3^tx^y1, y1' = y2^tx^y0, y2' = y0, y3' = y1.
- R7: Word k of state_in and state_out occupies bits 32k+31 .. 32k, with words ordered x0, y0, x1, y1, x2, y2, x3, y3 from k = 0.
- R8: A start pulse while busy is high has no effect: the running step count, the result and the done timing are those of the original request.
- R9: Done lasts exactly one cycle. Between runs, state_out holds the last result and changes only after a start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a permutation; accepted only while busy is low |
| steps | input | 4 | Number of steps to run, captured with start |
| state_in | input | 256 | Initial state, word 0 (x0) in the low 32 bits |
| state_out | output | 256 | Current or final state, same word order |
| busy | output | 1 | High while steps are being computed |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
The checker watches the sequencing on every cycle. It checks that busy lasts exactly the captured step count, that done coincides with busy falling and lasts one cycle, that a zero-step request returns its input at once, that a start during a run never ends it early, and that the output is frozen while idle. It cannot see the arithmetic of the step. The constant and counter injection, the box rotations, the linear mixing and the word order are shown only by the bench's comparisons against its own model. That model is swept over every step count from 0 to 15 with several state patterns, including runs disturbed by extra start pulses.

// File: rtl/arx_perm_pkg.sv
package arx_perm_pkg;

    localparam int WORD_W   = 32;
    localparam int N_BRANCH = 4;
    localparam int N_WORDS  = 2 * N_BRANCH;
    localparam int STATE_W  = N_WORDS * WORD_W;
    localparam int HALF     = N_BRANCH / 2;
    localparam int N_KONST  = 8;
    localparam int KIDX_W   = $clog2(N_KONST);

    typedef logic [WORD_W-1:0] word_t;

    // x sits in the low half so that word 2i is x_i and word 2i+1 is y_i
    typedef struct packed {
        word_t y;
        word_t x;
    } branch_t;

    typedef branch_t [N_BRANCH-1:0] state_t;

    function automatic word_t rotr(word_t w, int unsigned r);
        return (w >> r) | (w << (WORD_W - r));
    endfunction

    // linear mixing helper of the Feistel layer
    function automatic word_t mix_l(word_t v);
        return rotr(v ^ (v << 16), 16);
    endfunction

    function automatic word_t konst(logic [KIDX_W-1:0] idx);
        word_t k;
        case (idx)
            3'd0:    k = 32'hB7E1_5162;
            3'd1:    k = 32'hBF71_5880;
            3'd2:    k = 32'h38B4_DA56;
            3'd3:    k = 32'h324E_7738;
            3'd4:    k = 32'hBB11_85EB;
            3'd5:    k = 32'h4F7C_7B57;
            3'd6:    k = 32'hCFBF_A1C8;
            default: k = 32'hC2B3_293D;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/arx_perm_box.sv
module arx_perm_box
    import arx_perm_pkg::*;
(
    input  branch_t b_in,
    input  word_t   rkey,
    output branch_t b_out
);
    // rotation amounts of the four rounds: first applied to y, second to x
    localparam int unsigned RA0 = 31, RB0 = 24;
    localparam int unsigned RA1 = 17, RB1 = 17;
    localparam int unsigned RB2 = 31;
    localparam int unsigned RA3 = 24, RB3 = 16;

    word_t xv, yv;

    always_comb begin
        xv = b_in.x;
        yv = b_in.y;
        // round 0
        xv = xv + rotr(yv, RA0);
        yv = yv ^ rotr(xv, RB0);
        xv = xv ^ rkey;
        // round 1
        xv = xv + rotr(yv, RA1);
        yv = yv ^ rotr(xv, RB1);
        xv = xv ^ rkey;
        // round 2: no rotation on the add
        xv = xv + yv;
        yv = yv ^ rotr(xv, RB2);
        xv = xv ^ rkey;
        // round 3
        xv = xv + rotr(yv, RA3);
        yv = yv ^ rotr(xv, RB3);
        xv = xv ^ rkey;
        b_out.x = xv;
        b_out.y = yv;
    end

endmodule

// File: rtl/arx_perm_linear.sv
module arx_perm_linear
    import arx_perm_pkg::*;
(
    input  state_t s_in,
    output state_t s_out
);
    word_t  fold_x, fold_y;
    word_t  tx, ty;
    state_t right_m;

    always_comb begin
        fold_x = '0;
        fold_y = '0;
        for (int i = 0; i < HALF; i++) begin
            fold_x = fold_x ^ s_in[i].x;
            fold_y = fold_y ^ s_in[i].y;
        end
        tx = mix_l(fold_x);
        ty = mix_l(fold_y);
    end

    // Feistel part: right branches take the mixed left half
    always_comb begin
        right_m = s_in;
        for (int j = HALF; j < N_BRANCH; j++) begin
            right_m[j].x = s_in[j].x ^ ty;
            right_m[j].y = s_in[j].y ^ tx;
        end
    end

    // branch permutation with left/right swap
    genvar gi;
    generate
        for (gi = 0; gi < HALF; gi++) begin : g_perm
            localparam int SRC_R = HALF + ((gi + 1) % HALF);
            localparam int SRC_L = (gi + 1) % HALF;
            assign s_out[gi].x      = right_m[SRC_R].x ^ s_in[SRC_L].x;
            assign s_out[gi].y      = right_m[SRC_R].y ^ s_in[SRC_L].y;
            assign s_out[gi + HALF] = s_in[gi];
        end
    endgenerate

endmodule

// File: rtl/arx_perm_step.sv
module arx_perm_step
    import arx_perm_pkg::*;
#(
    parameter int STEP_W = 4
) (
    input  state_t            cur,
    input  logic [STEP_W-1:0] step_idx,
    output state_t            nxt
);
    state_t injected;
    state_t boxed;

    always_comb begin
        injected      = cur;
        injected[0].y = cur[0].y ^ konst(step_idx[KIDX_W-1:0]);
        injected[1].y = cur[1].y ^ {{(WORD_W-STEP_W){1'b0}}, step_idx};
    end

    genvar gb;
    generate
        for (gb = 0; gb < N_BRANCH; gb++) begin : g_box
            localparam logic [KIDX_W-1:0] KI = KIDX_W'(gb);
            arx_perm_box u_box (
                .b_in  (injected[gb]),
                .rkey  (konst(KI)),
                .b_out (boxed[gb])
            );
        end
    endgenerate

    arx_perm_linear u_lin (
        .s_in  (boxed),
        .s_out (nxt)
    );

endmodule

// File: rtl/arx_perm_ctrl.sv
module arx_perm_ctrl #(
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [STEP_W-1:0] steps,
    output logic              load,
    output logic              advance,
    output logic [STEP_W-1:0] step_idx,
    output logic              busy,
    output logic              done
);
    logic [STEP_W-1:0] target_q;
    logic [STEP_W-1:0] idx_nx;

    assign load     = start && !busy;
    assign advance  = busy;
    assign idx_nx   = step_idx + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            step_idx <= '0;
            target_q <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                step_idx <= '0;
                target_q <= steps;
                if (steps == '0) begin
                    done <= 1'b1;
                end else begin
                    busy <= 1'b1;
                end
            end else if (busy) begin
                step_idx <= idx_nx;
                if (idx_nx == target_q) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/arx_perm_core.sv
module arx_perm_core
    import arx_perm_pkg::*;
#(
    parameter int STEP_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [STEP_W-1:0]  steps,
    input  logic [STATE_W-1:0] state_in,
    output logic [STATE_W-1:0] state_out,
    output logic               busy,
    output logic               done
);
    logic              load, advance;
    logic [STEP_W-1:0] step_idx;
    state_t            state_q, state_nx;

    arx_perm_ctrl #(.STEP_W(STEP_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .steps    (steps),
        .load     (load),
        .advance  (advance),
        .step_idx (step_idx),
        .busy     (busy),
        .done     (done)
    );

    arx_perm_step #(.STEP_W(STEP_W)) u_step (
        .cur      (state_q),
        .step_idx (step_idx),
        .nxt      (state_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (load) begin
            state_q <= state_t'(state_in);
        end else if (advance) begin
            state_q <= state_nx;
        end
    end

    assign state_out = state_q;

endmodule

// File: rtl/arx_perm_core_chk.sv
module arx_perm_core_chk #(
    parameter int STEP_W  = 4,
    parameter int STATE_W = 256
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [STEP_W-1:0]  steps,
    input logic [STATE_W-1:0] state_in,
    input logic [STATE_W-1:0] state_out,
    input logic               busy,
    input logic               done
);
    logic [STEP_W:0] run_len;
    logic [STEP_W:0] run_tgt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
            run_tgt <= '0;
        end else if (start && !busy) begin
            run_len <= '0;
            run_tgt <= {1'b0, steps};
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end
    end

    p_len_exact_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && run_len == run_tgt));

    p_len_bound_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < run_tgt));

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && steps != '0) |=> (busy && !done && state_out == $past(state_in)));

    p_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && steps == '0) |=> (done && !busy && state_out == $past(state_in)));

    p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && start && (run_len + 1'b1) < run_tgt) |=> (busy && !done));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(state_out));

endmodule

bind arx_perm_core arx_perm_core_chk #(.STEP_W(STEP_W), .STATE_W(arx_perm_pkg::STATE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .steps     (steps),
    .state_in  (state_in),
    .state_out (state_out),
    .busy      (busy),
    .done      (done)
);

// File: tb/sim_arx_perm_core.sv
`timescale 1ns/1ps
module sim_arx_perm_core;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [3:0]   steps = '0;
    logic [255:0] state_in = '0;
    logic [255:0] state_out;
    logic         busy, done;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    arx_perm_core u0 (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .steps     (steps),
        .state_in  (state_in),
        .state_out (state_out),
        .busy      (busy),
        .done      (done)
    );

    function automatic logic [31:0] tb_k(int i);
        case (i)
            0: return 32'hB7E15162;
            1: return 32'hBF715880;
            2: return 32'h38B4DA56;
            3: return 32'h324E7738;
            4: return 32'hBB1185EB;
            5: return 32'h4F7C7B57;
            6: return 32'hCFBFA1C8;
            default: return 32'hC2B3293D;
        endcase
    endfunction

    function automatic logic [31:0] rr(logic [31:0] w, int r);
        if (r == 0) return w;
        return (w >> r) | (w << (32 - r));
    endfunction

    function automatic logic [255:0] model_step(logic [255:0] st, int s);
        logic [31:0] x [4];
        logic [31:0] y [4];
        logic [31:0] nx [4];
        logic [31:0] ny [4];
        logic [31:0] tx, ty, c;
        logic [255:0] r;
        for (int i = 0; i < 4; i++) begin
            x[i] = st[64*i +: 32];
            y[i] = st[64*i+32 +: 32];
        end
        y[0] = y[0] ^ tb_k(s % 8);
        y[1] = y[1] ^ 32'(s);
        for (int i = 0; i < 4; i++) begin
            c = tb_k(i);
            x[i] = x[i] + rr(y[i], 31); y[i] = y[i] ^ rr(x[i], 24); x[i] = x[i] ^ c;
            x[i] = x[i] + rr(y[i], 17); y[i] = y[i] ^ rr(x[i], 17); x[i] = x[i] ^ c;
            x[i] = x[i] + y[i];         y[i] = y[i] ^ rr(x[i], 31); x[i] = x[i] ^ c;
            x[i] = x[i] + rr(y[i], 24); y[i] = y[i] ^ rr(x[i], 16); x[i] = x[i] ^ c;
        end
        tx = x[0] ^ x[1]; tx = rr(tx ^ (tx << 16), 16);
        ty = y[0] ^ y[1]; ty = rr(ty ^ (ty << 16), 16);
        nx[0] = x[3] ^ ty ^ x[1]; nx[1] = x[2] ^ ty ^ x[0]; nx[2] = x[0]; nx[3] = x[1];
        ny[0] = y[3] ^ tx ^ y[1]; ny[1] = y[2] ^ tx ^ y[0]; ny[2] = y[0]; ny[3] = y[1];
        for (int i = 0; i < 4; i++) begin
            r[64*i +: 32]    = nx[i];
            r[64*i+32 +: 32] = ny[i];
        end
        return r;
    endfunction

    function automatic logic [255:0] model_perm(logic [255:0] st, int n);
        logic [255:0] r = st;
        for (int s = 0; s < n; s++) r = model_step(r, s);
        return r;
    endfunction

    function automatic logic [255:0] pattern(int p);
        logic [255:0] r;
        for (int k = 0; k < 8; k++) begin
            case (p)
                0: r[32*k +: 32] = 32'h0;
                1: r[32*k +: 32] = 32'hFFFFFFFF;
                2: r[32*k +: 32] = 32'(k);
                default: r[32*k +: 32] = 32'(k + 1) * 32'h9E3779B9;
            endcase
        end
        return r;
    endfunction

    task automatic check_bit(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic check_int(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_vec(string tag, logic [255:0] act, logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // one run; disturb drives extra start pulses with other data while busy
    task automatic run_one(int n, logic [255:0] st, bit disturb);
        int k;
        logic [255:0] expv;
        expv = model_perm(st, n);
        @(negedge clk);
        start = 1'b1; steps = 4'(n); state_in = st;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        if (n == 0) begin
            check_bit("R3 busy stays low", busy, 1'b0);
            check_bit("R3 done at once", done, 1'b1);
            check_vec("R3 R7 state unchanged", state_out, st);
        end else begin
            check_bit("R2 busy after start", busy, 1'b1);
            check_vec("R2 R7 state loaded", state_out, st);
        end
        while (!done && k < 40) begin
            if (disturb) begin
                start = 1'b1; steps = 4'd1; state_in = ~st;
            end
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        check_int(disturb ? "R8 done latency with extra start" : "R2 done latency", k, n);
        check_bit("R2 busy low with done", busy, 1'b0);
        check_vec(disturb ? "R8 result with extra start" : "R4 R5 R6 R7 result", state_out, expv);
        @(negedge clk);
        check_bit("R9 done one cycle", done, 1'b0);
        @(negedge clk);
        check_vec("R9 output held", state_out, expv);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_bit("R1 busy in reset", busy, 1'b0);
        check_bit("R1 done in reset", done, 1'b0);
        check_vec("R1 state in reset", state_out, '0);
        rst = 1'b0;
        for (int p = 0; p < 4; p++) begin
            for (int n = 0; n < 16; n++) begin
                run_one(n, pattern(p), 1'b0);
            end
        end
        for (int n = 2; n < 16; n += 3) begin
            run_one(n, pattern(3) ^ pattern(2), 1'b1);
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule